// File: doc/BRIEF.md
# Sprite Table Copy Engine with Bus-Conflict Masking

This block copies one page of system memory, byte by byte, into a small object-attribute RAM. A CPU write of value V to the start register sets the source address to V×256 and the destination index to 0. A fixed startup delay follows. After it, the engine moves one byte every four clock cycles until the whole table has been written. A second write to the start register during a transfer restarts the copy from the new page.

Sources at or above 0xE000 are treated as the echo region. The mono variant reads them at the alias address with bit 13 cleared. The color variant reads nothing there and stores the current mask value instead.

When the CPU writes to the bus the engine is using (the surrounding decode raises `cpu_conflict`), the engine can spoil the next copied byte through an AND mask, or place the CPU's data directly into the table. Which of these happens depends on static variant inputs. In those cases the CPU write is kept from reaching memory.

Top module: `oam_dma_engine`

## Requirements
- R1: A CPU write with `cpu_addr` equal to START_ADDR (default 0xFF46) and data V makes `busy` high from the next cycle, sets the source address to V<<8 and points the destination (`oam_addr`) at 0.
- R2: A start write while `busy` is high abandons the running copy. The next table write goes to index 0 from the new page, START_DELAY+1 cycles after the restart edge.
- R3: The read request for byte k is issued START_DELAY+4k cycles after the start edge, at the source address V*256+k. The returned data is written to index k one cycle later, so writes are four cycles apart.
- R4: A transfer writes XFER_LEN (160) bytes. `busy` stays high through the cycle of the last write and is low in the following cycle.
- R5: Mono variant (`cfg_color`=0): a source at or above 0xE000 is read from the source address with bit 13 cleared.
- R6: Color variant (`cfg_color`=1): a source at or above 0xE000 issues no read request, and the byte written is the current mask (0xFF when no conflict is pending).
- R7: A conflicting CPU write (`cpu_wr` and `cpu_conflict` while busy, not to the start register) is acted on when `cfg_color`=1 or the current source is above 0xC000. It then sets the mask to 0x00 if the source is below 0xC000, else 0xFF, and `cpu_wr_allow` is low. Otherwise `cpu_wr_allow` stays high and the copy is unchanged.
- R8: With `cfg_mask_from_data`=1 and the source above 0xC000, an acted-on conflict makes the CPU data itself the mask for the next byte.
- R9: With `cfg_direct_store`=1, `cfg_mask_from_data`=0, the source above 0xC000 and a CPU address below 0xFE00, an acted-on conflict writes the CPU data at once to the current destination index. The engine skips its own write for that step but still advances the index. A CPU address at or above 0xFE00 gives only the mask rule of R7.
- R10: The mask is applied to exactly one byte and returns to 0xFF after every byte step.
- R11: Reset clears `busy`, leaves the mask at 0xFF and clears any pending skip, so the first copy after reset is unmasked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_color | input | 1 | Selects the color echo and conflict behaviour |
| cfg_mask_from_data | input | 1 | Conflict data becomes the mask for sources above 0xC000 |
| cfg_direct_store | input | 1 | Conflict data is stored directly into the table for sources above 0xC000 |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_addr | input | 16 | CPU write address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_conflict | input | 1 | The CPU write targets the bus the engine is using |
| cpu_wr_allow | output | 1 | Low when the CPU write must not be committed |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_addr | output | 16 | Memory read address |
| mem_rd_data | input | 8 | Read data, valid the cycle after the request |
| oam_we | output | 1 | Table write enable |
| oam_addr | output | 8 | Table write index |
| oam_wdata | output | 8 | Table write data |
| busy | output | 1 | Transfer in progress |

## Verification
The bench aims conflicts at chosen byte steps. One of these sits exactly at a source of 0xC000 in color mode, where a wrong comparison would apply a 0x00 mask instead of 0xFF. The byte after each conflict is checked, so a mask that is not restored would corrupt the rest of the page. A direct-store conflict is checked for the CPU byte landing at the right index and for the engine's own write being dropped; an engine that forgets to skip would put two writes into that slot. Echo pages are checked in both variants: a mono engine that fails to clear bit 13 returns the wrong data, and a color engine that still reads shows up in the read count. A restart in the middle of a page is checked against the byte order and the timing of the new page, which catches an engine that keeps the old destination index.

// File: rtl/oam_dma_engine.sv
module oam_dma_engine #(
  parameter int AW = 16,
  parameter int DW = 8,
  parameter int IDX_W = 8,
  parameter int XFER_LEN = 160,
  parameter int START_DELAY = 8,
  parameter int STEP_CYCLES = 4,
  parameter int PAGE_SHIFT = 8,
  parameter int ECHO_BIT = 13,
  parameter logic [AW-1:0] START_ADDR = 16'hFF46,
  parameter logic [AW-1:0] HIGH_BASE = 16'hC000,
  parameter logic [AW-1:0] ECHO_BASE = 16'hE000,
  parameter logic [AW-1:0] OAM_BASE = 16'hFE00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_color,
  input  logic             cfg_mask_from_data,
  input  logic             cfg_direct_store,
  input  logic             cpu_wr,
  input  logic [AW-1:0]    cpu_addr,
  input  logic [DW-1:0]    cpu_wdata,
  input  logic             cpu_conflict,
  output logic             cpu_wr_allow,
  output logic             mem_rd_req,
  output logic [AW-1:0]    mem_rd_addr,
  input  logic [DW-1:0]    mem_rd_data,
  output logic             oam_we,
  output logic [IDX_W-1:0] oam_addr,
  output logic [DW-1:0]    oam_wdata,
  output logic             busy
);
  localparam int WAIT_W = $clog2(START_DELAY + 1);
  localparam int PH_W = $clog2(STEP_CYCLES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(XFER_LEN - 1);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(STEP_CYCLES - 1);
  localparam logic [DW-1:0] ONES = '1;
  localparam logic [AW-1:0] ECHO_CLR = ~(AW'(1) << ECHO_BIT);

  logic              busy_q, skip_q;
  logic [WAIT_W-1:0] wait_q;
  logic [PH_W-1:0]   phase_q;
  logic [AW-1:0]     src_q;
  logic [IDX_W-1:0]  dest_q;
  logic [DW-1:0]     mask_q;

  wire start_wr   = cpu_wr && (cpu_addr == START_ADDR);
  wire clash      = busy_q && cpu_wr && cpu_conflict && !start_wr;
  wire src_high   = src_q > HIGH_BASE;
  wire src_low    = src_q < HIGH_BASE;
  wire taken      = clash && (cfg_color || src_high);
  wire oam_target = cpu_addr >= OAM_BASE;
  wire poke       = taken && !cfg_mask_from_data && cfg_direct_store && src_high && !oam_target;
  wire running    = busy_q && (wait_q == '0);
  wire rd_phase   = running && (phase_q == '0);
  wire wr_phase   = running && (phase_q == PH_W'(1));
  wire in_echo    = src_q >= ECHO_BASE;
  wire echo_fill  = in_echo && cfg_color;

  logic [DW-1:0] clash_mask;
  always_comb begin
    clash_mask = src_low ? '0 : ONES;
    if (cfg_mask_from_data && src_high) clash_mask = cpu_wdata;
  end

  assign cpu_wr_allow = !taken;
  assign mem_rd_req   = rd_phase && !echo_fill;
  assign mem_rd_addr  = in_echo ? (src_q & ECHO_CLR) : src_q;
  assign oam_we       = poke || (wr_phase && !skip_q);
  assign oam_addr     = dest_q;
  assign oam_wdata    = poke ? cpu_wdata : (echo_fill ? mask_q : (mem_rd_data & mask_q));
  assign busy         = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      skip_q  <= 1'b0;
      wait_q  <= '0;
      phase_q <= '0;
      src_q   <= '0;
      dest_q  <= '0;
      mask_q  <= ONES;
    end else if (start_wr) begin
      busy_q  <= 1'b1;
      skip_q  <= 1'b0;
      wait_q  <= WAIT_W'(START_DELAY);
      phase_q <= '0;
      src_q   <= AW'(cpu_wdata) << PAGE_SHIFT;
      dest_q  <= '0;
      mask_q  <= ONES;
    end else if (busy_q) begin
      if (wait_q != '0) wait_q <= wait_q - 1'b1;
      else phase_q <= (phase_q == LAST_PH) ? '0 : phase_q + 1'b1;
      if (wr_phase) begin
        src_q  <= src_q + 1'b1;
        dest_q <= dest_q + 1'b1;
        skip_q <= 1'b0;
        mask_q <= taken ? clash_mask : ONES;
        if (dest_q == LAST_IDX) busy_q <= 1'b0;
      end else begin
        if (taken) mask_q <= clash_mask;
        if (poke) skip_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/oam_dma_engine_chk.sv
module oam_dma_engine_chk #(
  parameter int AW = 16,
  parameter int IDX_W = 8,
  parameter int XFER_LEN = 160,
  parameter logic [AW-1:0] START_ADDR = 16'hFF46
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cpu_wr,
  input logic [AW-1:0]    cpu_addr,
  input logic             cpu_wr_allow,
  input logic             mem_rd_req,
  input logic             oam_we,
  input logic [IDX_W-1:0] oam_addr,
  input logic             busy
);
  // R1
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && cpu_addr == START_ADDR) |=> (busy && oam_addr == '0));
  // R4
  we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oam_we |-> busy);
  // R3
  rd_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |=> !mem_rd_req);
  // R3
  rd_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_req |-> busy);
  // R7
  idle_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cpu_wr_allow);
  // R4
  end_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(oam_addr) == IDX_W'(XFER_LEN - 1)));
endmodule

bind oam_dma_engine oam_dma_engine_chk #(
  .AW(AW), .IDX_W(IDX_W), .XFER_LEN(XFER_LEN), .START_ADDR(START_ADDR)
) chk_i (.*);

// File: tb/oam_dma_engine_tb_top.sv
`timescale 1ns/100ps
module oam_dma_engine_tb_top;
  localparam int D = 8;
  localparam int LEN = 160;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_color = 0, cfg_mask_from_data = 0, cfg_direct_store = 0;
  logic cpu_wr = 0, cpu_conflict = 0;
  logic [15:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic cpu_wr_allow, mem_rd_req, oam_we, busy;
  logic [15:0] mem_rd_addr;
  logic [7:0] mem_rd_data = '0, oam_wdata;
  logic [7:0] oam_addr;

  int checks = 0, errors = 0, cyc = 0, rd_cnt = 0;
  int first_we = -1, last_we = -1;
  string tag = "R11";
  logic [15:0] expq[$];

  always #2.5 clk = ~clk;

  oam_dma_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_color(cfg_color), .cfg_mask_from_data(cfg_mask_from_data),
    .cfg_direct_store(cfg_direct_store), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_conflict(cpu_conflict), .cpu_wr_allow(cpu_wr_allow),
    .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .oam_we(oam_we), .oam_addr(oam_addr), .oam_wdata(oam_wdata), .busy(busy));

  function automatic logic [7:0] mem_f(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] src_byte(input logic [15:0] s, input logic col, input logic [7:0] m);
    if (s >= 16'hE000) return col ? m : (mem_f(s & 16'hDFFF) & m);
    return mem_f(s) & m;
  endfunction

  task automatic check(input string t, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", t, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_rd_req) begin
      mem_rd_data <= mem_f(mem_rd_addr);
      rd_cnt <= rd_cnt + 1;
    end
  end

  // monitor: pops the scoreboard on every table write
  always @(negedge clk) begin
    if (rst_n && oam_we) begin
      if (first_we < 0) first_we = cyc;
      last_we = cyc;
      if (expq.size() == 0) check({tag, " unexpected write"}, {oam_addr, oam_wdata}, 0);
      else check({tag, " table write"}, {oam_addr, oam_wdata}, expq.pop_front());
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic push_page(input logic [7:0] page, input logic col, input int from, input int upto,
                           input int cj, input logic [7:0] cm, input logic cdir, input logic [7:0] cdata);
    for (int k = from; k < upto; k++) begin
      logic [15:0] s = {page, 8'h00} + 16'(k);
      if (k == cj && cdir) expq.push_back({8'(k), cdata});
      else expq.push_back({8'(k), src_byte(s, col, (k == cj) ? cm : 8'hFF)});
    end
  endtask

  task automatic do_start(input logic [7:0] page, output int t0);
    @(posedge clk); #1;
    cpu_wr = 1; cpu_addr = 16'hFF46; cpu_wdata = page; cpu_conflict = 0;
    @(posedge clk); #1;
    t0 = cyc;
    cpu_wr = 0;
    check({tag, " busy after start"}, busy, 1);
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (busy) @(negedge clk);
    check({tag, " all bytes written"}, expq.size(), 0);
  endtask

  // driver: cj < 0 means no conflict
  task automatic run_case(input string t, input logic [7:0] page, input logic col, input logic mfd,
                          input logic dsto, input int cj, input logic [15:0] caddr, input logic [7:0] cdata);
    logic [15:0] sc;
    logic tk, dir;
    logic [7:0] m;
    int t0;
    tag = t;
    cfg_color = col; cfg_mask_from_data = mfd; cfg_direct_store = dsto;
    sc = {page, 8'h00} + 16'(cj < 0 ? 0 : cj);
    tk = col || (sc > 16'hC000);
    m = (sc < 16'hC000) ? 8'h00 : 8'hFF;
    dir = 0;
    if (mfd && sc > 16'hC000) m = cdata;
    else if (dsto && sc > 16'hC000 && caddr < 16'hFE00) dir = 1;
    if (cj < 0 || !tk) push_page(page, col, 0, LEN, -1, 8'hFF, 0, 0);
    else push_page(page, col, 0, LEN, cj, m, dir, cdata);
    first_we = -1; rd_cnt = 0;
    do_start(page, t0);
    if (cj >= 0) begin
      repeat (D - 2 + 4 * cj) @(posedge clk);
      #1;
      cpu_wr = 1; cpu_conflict = 1; cpu_addr = caddr; cpu_wdata = cdata;
      #1 check({t, " cpu write allow"}, cpu_wr_allow, !tk);
      @(posedge clk); #1;
      cpu_wr = 0; cpu_conflict = 0;
    end
    wait_done();
    check({t, " first write timing R3"}, first_we - t0, D + 1);
    check({t, " last write timing R4"}, last_we - t0, D + 1 + 4 * (LEN - 1));
    check({t, " busy low after last R4"}, cyc - last_we, 1);
    if (page >= 8'hE0 && col) check({t, " no echo reads"}, rd_cnt, 0);
    else check({t, " read count R3"}, rd_cnt, LEN);
  endtask

  initial begin
    int t0, t1;
    repeat (3) @(posedge clk);
    #1;
    check("R11 busy in reset", busy, 0);
    check("R11 no write in reset", oam_we, 0);
    check("R11 allow in reset", cpu_wr_allow, 1);
    rst_n = 1;
    run_case("R3 R4 R11 plain page", 8'h12, 0, 0, 0, -1, 16'h8000, 8'h00);
    run_case("R5 mono echo", 8'hE5, 0, 0, 0, -1, 16'h8000, 8'h00);
    run_case("R6 color echo", 8'hF0, 1, 0, 0, -1, 16'h8000, 8'h00);
    run_case("R7 R10 color low conflict", 8'h30, 1, 0, 0, 5, 16'h8010, 8'h55);
    run_case("R7 mono low ignored", 8'h30, 0, 0, 0, 5, 16'h8010, 8'h55);
    run_case("R7 color at C000", 8'hC0, 1, 0, 0, 0, 16'h8010, 8'h33);
    run_case("R8 data mask", 8'hD0, 0, 1, 0, 7, 16'hD100, 8'h0F);
    run_case("R9 direct store", 8'hD0, 0, 0, 1, 9, 16'hC123, 8'hA7);
    run_case("R9 table target", 8'hD0, 0, 0, 1, 9, 16'hFE10, 8'hA7);
    // R2 restart after ten bytes
    tag = "R2 restart";
    cfg_color = 0; cfg_mask_from_data = 0; cfg_direct_store = 0;
    push_page(8'h40, 0, 0, 10, -1, 8'hFF, 0, 0);
    push_page(8'h50, 0, 0, LEN, -1, 8'hFF, 0, 0);
    do_start(8'h40, t0);
    repeat (D + 38) @(posedge clk);
    first_we = -1;
    do_start(8'h50, t1);
    check("R2 ten old bytes written", expq.size(), LEN);
    wait_done();
    check("R2 first write after restart", first_we - t1, D + 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule